// File: doc/BRIEF.md
# Serial-Controlled Successive-Approximation Converter Front End

This block is the digital half of a 14-bit successive-approximation converter reached through a four-wire serial port. A host lowers chip select and toggles the serial clock. Any zeros it sends first are skipped. The first one bit opens an eight-bit command. That command picks an input channel, single-ended or differential input, unipolar or bipolar coding, and one of four clock or power modes. The block then tracks, holds and converts the sample word. It shifts the result out most significant bit first and signals progress on a strobe pin.

The analog input arrives as a 14-bit word, `sample_i`. It is read as unsigned in unipolar mode and as two's complement in bipolar mode. The conversion is a true bit-by-bit search: a trial register is compared against that word. The serial pins are oversampled in the system clock domain.

Each command chooses one of two ways to run the conversion. In external mode the serial clock paces every decision. In internal mode a divided system clock paces the decisions and the host waits for the strobe. The two data and strobe pins are modelled as a value plus an output-enable, so they stand in for tri-state pins.

Top module: `sar_serial_fe`

## Requirements
- R1: While chip select is low and no command is open, zero bits sampled on DIN are ignored, however many there are. The first one bit sampled starts a command and is its bit 7.
- R2: Command fields, MSB first:
  - bit 7: start.
  - bits 6:4: channel.
  - bit 3: input type (1 = single-ended, 0 = differential).
  - bit 2: coding (1 = unipolar, 0 = bipolar).
  - bits 1:0: mode (00 = full power-down, 01 = fast power-down, 10 = internal conversion clock, 11 = serial-clock conversion).
  
  `unipolar_o` and `ext_clk_o` take the new values on the 8th falling edge. `ext_clk_o` changes only for mode codes 10 and 11.
- R3: DIN is sampled on rising serial-clock edges. DOUT and, in external mode, the strobe change only after falling edges.
- R4: `chan_o` and `single_o` take the new values on the 5th falling edge of a command and not before. On the 8th falling edge, `sample_i` is held and `track_o` goes low. Later changes of `sample_i` do not alter the result.
- R5: In external mode the strobe rises on falling edge 9 and falls on falling edge 11. The result bits appear MSB first on falling edges 11 to 24. `result_o` carries the result by falling edge 23.
- R6: In internal mode the strobe is low from the 8th falling edge for 15 periods of a conversion clock of CONV_DIV system clocks, then rises. On later falling edges DOUT gives one 0, then the result MSB first.
- R7: `dout_en_o` is low whenever chip select is high. `sstrb_en_o` is low while chip select is high only in external mode; in internal mode it stays high.
- R8: After reset the block is in internal mode with the strobe high, `track_o` high and `result_o` zero. Until a conversion completes, DOUT gives only zeros.
- R9: Mode codes 00 and 01 set exactly one of `pd_full_o` or `pd_fast_o`. They start no conversion and leave the strobe unchanged. The next start bit clears both flags.
- R10: The result equals the held word: straight binary in unipolar mode, two's complement in bipolar mode.
- R11: `result_o` keeps the last result until another conversion completes. Power-down commands and aborted commands do not change it.
- R12: Raising chip select before the 8th falling edge drops the partial command. No conversion starts, and the next command is decoded from its own start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, oversampled |
| cs_n_i | input | 1 | Active-low chip select |
| din_i | input | 1 | Serial command input |
| sample_i | input | RES_W | Digitised analog input word |
| dout_o | output | 1 | Serial result bit |
| dout_en_o | output | 1 | Drive enable for dout_o |
| sstrb_o | output | 1 | Strobe level |
| sstrb_en_o | output | 1 | Drive enable for sstrb_o |
| chan_o | output | 3 | Selected channel |
| single_o | output | 1 | 1 = single-ended input |
| unipolar_o | output | 1 | 1 = unipolar coding |
| ext_clk_o | output | 1 | 1 = serial-clock conversion mode |
| pd_full_o | output | 1 | Full power-down active |
| pd_fast_o | output | 1 | Fast power-down active |
| track_o | output | 1 | 1 = tracking, 0 = holding |
| result_o | output | RES_W | Last completed conversion |

## Verification
The hardest case to reach is the exact instant of the hold. The held word must be the value on `sample_i` at the 8th falling edge, not a later one. The stimulus therefore inverts `sample_i` immediately after every command's 8th falling edge, so a late capture shows up in the result bits.

Internal-mode readout is also hard to reach. It needs the host to wait for the strobe and then clock one padding bit. The bench polls the strobe and times how long it stays low before clocking out the result.

Aborted commands and the wake-up from power-down need chip select to move partway through a byte. Directed sequences bring both about.

// File: rtl/sar_fe_pkg.sv
package sar_fe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CTRL = 2'd1,
        ST_EXT  = 2'd2,
        ST_INT  = 2'd3
    } fe_state_e;

    localparam int CMD_W   = 8;
    localparam int CHAN_W  = 3;
    localparam int FE_MUX  = 5;   // falling edge that switches the input selection
    localparam int FE_HOLD = 8;   // falling edge that freezes the sample
endpackage

// File: rtl/sar_fe_pin_sync.sv
module sar_fe_pin_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] pins_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb chain_d = {chain_q[STAGES-2:0], pins_i[b]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= chain_d;
        end

        assign pins_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/sar_fe_sar_step.sv
module sar_fe_sar_step #(
    parameter int W  = 14,
    parameter int PW = 4
) (
    input  logic [W-1:0]  trial_i,
    input  logic [W-1:0]  target_i,
    input  logic [PW-1:0] pos_i,
    output logic [W-1:0]  trial_o
);
    logic [W-1:0] cand;

    always_comb begin
        cand    = trial_i | (W'(1) << pos_i);
        trial_o = (cand <= target_i) ? cand : trial_i;
    end
endmodule

// File: rtl/sar_serial_fe.sv
module sar_serial_fe
    import sar_fe_pkg::*;
#(
    parameter int RES_W    = 14,
    parameter int CONV_DIV = 4,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             cs_n_i,
    input  logic             din_i,
    input  logic [RES_W-1:0] sample_i,
    output logic             dout_o,
    output logic             dout_en_o,
    output logic             sstrb_o,
    output logic             sstrb_en_o,
    output logic [2:0]       chan_o,
    output logic             single_o,
    output logic             unipolar_o,
    output logic             ext_clk_o,
    output logic             pd_full_o,
    output logic             pd_fast_o,
    output logic             track_o,
    output logic [RES_W-1:0] result_o
);
    localparam int FE_W   = $clog2(FE_HOLD + RES_W + 3);
    localparam int POS_W  = $clog2(RES_W);
    localparam int STEP_W = $clog2(RES_W + 1);
    localparam int DIV_W  = (CONV_DIV > 1) ? $clog2(CONV_DIV) : 1;
    localparam int SH_W   = RES_W + 2;

    localparam logic [FE_W-1:0] FE_MUX_C  = FE_W'(FE_MUX);
    localparam logic [FE_W-1:0] FE_HOLD_C = FE_W'(FE_HOLD);
    localparam logic [FE_W-1:0] FE_STB_ON = FE_W'(FE_HOLD + 1);
    localparam logic [FE_W-1:0] FE_STB_2  = FE_W'(FE_HOLD + 2);
    localparam logic [FE_W-1:0] FE_MSB    = FE_W'(FE_HOLD + 3);
    localparam logic [FE_W-1:0] FE_DONE   = FE_W'(FE_HOLD + 1 + RES_W);
    localparam logic [FE_W-1:0] FE_LAST   = FE_W'(FE_HOLD + 2 + RES_W);
    localparam logic [RES_W-1:0] MSB_MASK = RES_W'(1) << (RES_W - 1);

    typedef struct packed {
        fe_state_e         st;
        logic              sclk_prev;
        logic [CMD_W-1:0]  cmd;
        logic [FE_W-1:0]   fe;
        logic [CHAN_W-1:0] chan;
        logic              single;
        logic              uni;
        logic              ext;
        logic              pd_full;
        logic              pd_fast;
        logic              track;
        logic              sstrb;
        logic              dout;
        logic              done;
        logic [RES_W-1:0]  held;
        logic [RES_W-1:0]  sar;
        logic [RES_W-1:0]  result;
        logic [SH_W-1:0]   sh;
        logic [DIV_W-1:0]  div;
        logic [STEP_W-1:0] step;
    } regs_t;

    regs_t r_q, r_d;

    // oversampled pins: {din, cs_n, sclk}; chip select resets inactive
    logic [2:0] pins_s;
    sar_fe_pin_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({din_i, cs_n_i, sclk_i}),
        .pins_o (pins_s)
    );

    logic sclk_s, cs_s, din_s, rise_ev, fall_ev;
    assign sclk_s  = pins_s[0];
    assign cs_s    = pins_s[1];
    assign din_s   = pins_s[2];
    assign rise_ev = sclk_s & ~r_q.sclk_prev;
    assign fall_ev = ~sclk_s & r_q.sclk_prev;

    logic [FE_W-1:0]  fe_n;
    logic [POS_W-1:0] pos_fe, pos_step, pos, out_idx;
    logic [RES_W-1:0] target, sar_try, res_code;
    logic             ext_bit;

    assign fe_n     = r_q.fe + FE_W'(1);
    assign pos_fe   = POS_W'(FE_DONE - FE_W'(1) - fe_n);
    assign pos_step = POS_W'(RES_W - 1) - POS_W'(r_q.step);
    assign pos      = (r_q.st == ST_EXT) ? pos_fe : pos_step;
    assign target   = r_q.uni ? r_q.held : (r_q.held ^ MSB_MASK);
    assign res_code = r_q.uni ? r_q.sar : (r_q.sar ^ MSB_MASK);
    assign out_idx  = POS_W'(FE_LAST - fe_n);
    assign ext_bit  = r_q.sar[out_idx] ^ ((out_idx == POS_W'(RES_W - 1)) & ~r_q.uni);

    sar_fe_sar_step #(.W(RES_W), .PW(POS_W)) u_step (
        .trial_i  (r_q.sar),
        .target_i (target),
        .pos_i    (pos),
        .trial_o  (sar_try)
    );

    always_comb begin
        r_d           = r_q;
        r_d.done      = 1'b0;
        r_d.sclk_prev = sclk_s;

        // readout shifter runs on every falling edge while selected
        if (!cs_s && fall_ev) begin
            r_d.sh   = {r_q.sh[SH_W-2:0], 1'b0};
            r_d.dout = r_q.sh[SH_W-2];
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (!cs_s && rise_ev && din_s) begin
                    r_d.st      = ST_CTRL;
                    r_d.cmd     = CMD_W'(1);
                    r_d.fe      = '0;
                    r_d.pd_full = 1'b0;
                    r_d.pd_fast = 1'b0;
                end
            end
            ST_CTRL: begin
                if (cs_s) begin
                    r_d.st = ST_IDLE;
                end else if (rise_ev) begin
                    r_d.cmd = {r_q.cmd[CMD_W-2:0], din_s};
                end else if (fall_ev) begin
                    r_d.fe = fe_n;
                    if (fe_n == FE_MUX_C) begin
                        r_d.chan   = r_q.cmd[3:1];
                        r_d.single = r_q.cmd[0];
                    end
                    if (fe_n == FE_HOLD_C) begin
                        r_d.uni = r_q.cmd[2];
                        if (r_q.cmd[1]) begin
                            r_d.ext   = r_q.cmd[0];
                            r_d.held  = sample_i;
                            r_d.sar   = '0;
                            r_d.track = 1'b0;
                            r_d.sstrb = 1'b0;
                            r_d.div   = '0;
                            r_d.step  = '0;
                            r_d.st    = r_q.cmd[0] ? ST_EXT : ST_INT;
                        end else begin
                            r_d.pd_full = ~r_q.cmd[0];
                            r_d.pd_fast = r_q.cmd[0];
                            r_d.st      = ST_IDLE;
                        end
                    end
                end
            end
            ST_EXT: begin
                if (cs_s) begin
                    r_d.st    = ST_IDLE;
                    r_d.sstrb = 1'b0;
                    r_d.track = 1'b1;
                end else if (fall_ev) begin
                    r_d.fe = fe_n;
                    if (fe_n == FE_STB_ON) r_d.sstrb = 1'b1;
                    if (fe_n == FE_MSB)    r_d.sstrb = 1'b0;
                    if (fe_n >= FE_STB_ON && fe_n < FE_DONE) r_d.sar = sar_try;
                    r_d.dout = (fe_n >= FE_MSB) ? ext_bit : 1'b0;
                    if (fe_n == FE_DONE) begin
                        r_d.result = res_code;
                        r_d.done   = 1'b1;
                        r_d.track  = 1'b1;
                    end
                    if (fe_n == FE_LAST) r_d.st = ST_IDLE;
                end
            end
            ST_INT: begin
                if (r_q.div == DIV_W'(CONV_DIV - 1)) begin
                    r_d.div = '0;
                    if (r_q.step < STEP_W'(RES_W)) begin
                        r_d.sar  = sar_try;
                        r_d.step = r_q.step + STEP_W'(1);
                    end else begin
                        r_d.result = res_code;
                        r_d.sh     = {2'b00, res_code};
                        r_d.done   = 1'b1;
                        r_d.sstrb  = 1'b1;
                        r_d.track  = 1'b1;
                        r_d.st     = ST_IDLE;
                    end
                end else begin
                    r_d.div = r_q.div + DIV_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.sstrb <= 1'b1;
            r_q.track <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout_o     = r_q.dout;
    assign dout_en_o  = ~cs_s;
    assign sstrb_o    = r_q.sstrb;
    assign sstrb_en_o = ~(r_q.ext & cs_s);
    assign chan_o     = r_q.chan;
    assign single_o   = r_q.single;
    assign unipolar_o = r_q.uni;
    assign ext_clk_o  = r_q.ext;
    assign pd_full_o  = r_q.pd_full;
    assign pd_fast_o  = r_q.pd_fast;
    assign track_o    = r_q.track;
    assign result_o   = r_q.result;

    // R3: serial output moves only after a detected falling edge
    a_r3_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fall_ev) |-> $stable(r_q.dout));

    // R4: the held word is frozen for the whole internal conversion
    a_r4_held_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_INT && $past(r_q.st) == ST_INT) |-> $stable(r_q.held));

    // R5: external strobe only inside its two-edge window
    a_r5_ext_strobe_window: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_EXT && r_q.sstrb) |-> (r_q.fe == FE_STB_ON || r_q.fe == FE_STB_2));

    // R6: strobe low during internal conversion, step counter bounded
    a_r6_int_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_INT) |-> !r_q.sstrb);
    a_r6_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.step <= STEP_W'(RES_W));

    // R9: at most one power-down flavour
    a_r9_pd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.pd_full, r_q.pd_fast}));

    // R10: bit search reproduces the held word in either coding
    a_r10_result_matches: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (r_q.result == r_q.held));
endmodule

// File: tb/sar_serial_fe_test.sv
module sar_serial_fe_test;
    localparam int RES  = 14;
    localparam int DIV  = 4;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
    logic [RES-1:0] sample = '0;
    logic dout_o, dout_en_o, sstrb_o, sstrb_en_o, single_o, unipolar_o;
    logic ext_clk_o, pd_full_o, pd_fast_o, track_o;
    logic [2:0] chan_o;
    logic [RES-1:0] result_o;

    int n_chk = 0, n_err = 0;
    logic [2:0] exp_chan = '0;
    logic exp_ext = 1'b0;
    logic [RES-1:0] exp_result = '0;

    always #2 clk = ~clk;

    sar_serial_fe #(.RES_W(RES), .CONV_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
        .sample_i(sample), .dout_o(dout_o), .dout_en_o(dout_en_o),
        .sstrb_o(sstrb_o), .sstrb_en_o(sstrb_en_o), .chan_o(chan_o),
        .single_o(single_o), .unipolar_o(unipolar_o), .ext_clk_o(ext_clk_o),
        .pd_full_o(pd_full_o), .pd_fast_o(pd_fast_o), .track_o(track_o),
        .result_o(result_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [RES-1:0] encode(input int v);
        return RES'(v);
    endfunction

    // one serial clock period; d = dout after the fall, dh = dout just before it
    task automatic pulse(input logic b, output logic d, output logic s, output logic dh);
        din = b;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        dh = dout_o;
        sclk = 1'b0;
        repeat (HALF - 1) @(negedge clk);
        d = dout_o;
        s = sstrb_o;
    endtask

    task automatic release_cs();
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
        chk(dout_en_o == 1'b0, "R7 dout enable", dout_en_o, 0);
        chk(sstrb_en_o == !exp_ext, "R7 strobe enable", sstrb_en_o, !exp_ext);
    endtask

    task automatic conv(input logic [2:0] sel, input logic sgl, input logic uni,
                        input logic [1:0] pd, input int zeros, input logic [RES-1:0] code);
        logic d, s, dh, prev_d;
        logic [7:0] b;
        logic [RES-1:0] word;
        int n;
        b = {1'b1, sel, sgl, uni, pd};
        sample = code;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < zeros; i++) pulse(1'b0, d, s, dh);   // R1 leading zeros
        for (int i = 7; i >= 0; i--) begin
            pulse(b[i], d, s, dh);
            if (i == 7) chk(!pd_full_o && !pd_fast_o, "R9 wake on start", {pd_full_o, pd_fast_o}, 0);
            if (i == 4) chk(chan_o == exp_chan, "R4 channel before edge 5", chan_o, exp_chan);
            if (i == 3) begin
                exp_chan = sel;
                chk(chan_o == sel && single_o == sgl, "R1 R2 R4 channel at edge 5",
                    {chan_o, single_o}, {sel, sgl});
            end
        end
        sample = ~code;   // late change must not reach the result
        chk(unipolar_o == uni, "R2 coding", unipolar_o, uni);
        if (pd[1]) begin
            exp_ext = pd[0];
            chk(track_o == 1'b0, "R4 hold", track_o, 0);
        end
        chk(ext_clk_o == exp_ext, "R2 mode", ext_clk_o, exp_ext);
        if (pd == 2'b11) begin
            chk(sstrb_o == 1'b0, "R5 strobe idle", sstrb_o, 0);
            word = '0;
            prev_d = dout_o;
            for (int k = 9; k <= 24; k++) begin
                pulse(1'b0, d, s, dh);
                chk(s == (k == 9 || k == 10), "R5 strobe window", s, (k == 9 || k == 10));
                chk(dh == prev_d, "R3 no change on rise", dh, prev_d);
                prev_d = d;
                if (k >= 11) word = {word[RES-2:0], d};
                if (k == 23) chk(result_o == code, "R5 result by edge 23", result_o, code);
            end
            chk(word == code, "R5 R10 serial result", word, code);
            exp_result = code;
        end else if (pd == 2'b10) begin
            chk(sstrb_o == 1'b0, "R6 strobe low", sstrb_o, 0);
            n = 0;
            while (sstrb_o == 1'b0 && n < 2000) begin
                @(negedge clk);
                n++;
            end
            chk(n >= 15 * DIV - 6 && n <= 15 * DIV, "R6 conversion length", n, 15 * DIV);
            chk(track_o == 1'b1, "R4 track after conversion", track_o, 1);
            pulse(1'b0, d, s, dh);
            chk(d == 1'b0, "R6 padding bit", d, 0);
            word = '0;
            for (int k = 0; k < RES; k++) begin
                pulse(1'b0, d, s, dh);
                word = {word[RES-2:0], d};
            end
            chk(word == code, "R6 R10 serial result", word, code);
            exp_result = code;
        end else begin
            chk(pd_full_o == !pd[0] && pd_fast_o == pd[0], "R9 power-down flags",
                {pd_full_o, pd_fast_o}, {!pd[0], pd[0]});
            chk(sstrb_o == !exp_ext, "R9 no conversion strobe", sstrb_o, !exp_ext);
            chk(track_o == 1'b1, "R9 still tracking", track_o, 1);
        end
        chk(result_o == exp_result, "R11 result held", result_o, exp_result);
        release_cs();
    endtask

    task automatic partial(input logic [7:0] b, input int nb);
        logic d, s, dh;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 7; i > 7 - nb; i--) pulse(b[i], d, s, dh);
        if (nb >= 5) exp_chan = b[6:4];
        cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
        chk(sstrb_o == !exp_ext && track_o, "R12 abort starts nothing", {sstrb_o, track_o}, {!exp_ext, 1'b1});
        chk(result_o == exp_result, "R11 R12 result after abort", result_o, exp_result);
    endtask

    initial begin
        repeat (500000) @(posedge clk);
        n_err++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic d, s, dh;
        logic [RES-1:0] word;
        int v, r;
        logic [1:0] pdr;
        logic u;
        void'($urandom(32'd20240611));
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (HALF) @(negedge clk);
        // R8 reset state
        chk(sstrb_o == 1'b1 && sstrb_en_o == 1'b1, "R8 strobe at reset", {sstrb_o, sstrb_en_o}, 2'b11);
        chk(ext_clk_o == 1'b0, "R8 internal mode at reset", ext_clk_o, 0);
        chk(track_o == 1'b1 && result_o == '0, "R8 track and result", {track_o, result_o}, {1'b1, 14'h0});
        chk(dout_en_o == 1'b0, "R7 dout off with cs high", dout_en_o, 0);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        chk(dout_en_o == 1'b1, "R7 dout on with cs low", dout_en_o, 1);
        word = '0;
        for (int k = 0; k < 16; k++) begin
            pulse(1'b0, d, s, dh);
            word = word | RES'(d);
        end
        chk(word == '0, "R8 zeros before first result", word, 0);
        release_cs();

        conv(3'b111, 1'b1, 1'b1, 2'b11, 0, 14'h3FFF);
        conv(3'b000, 1'b1, 1'b1, 2'b11, 5, 14'h0000);
        conv(3'b101, 1'b0, 1'b0, 2'b10, 2, encode(-8192));
        conv(3'b010, 1'b1, 1'b0, 2'b10, 0, encode(8191));
        conv(3'b011, 1'b0, 1'b0, 2'b11, 1, encode(-1));
        conv(3'b001, 1'b1, 1'b1, 2'b00, 3, 14'h1234);
        conv(3'b110, 1'b1, 1'b1, 2'b10, 0, 14'h2AAA);
        conv(3'b100, 1'b0, 1'b1, 2'b01, 0, 14'h0555);
        partial(8'b1101_1011, 6);
        partial(8'b1011_0011, 3);
        conv(3'b011, 1'b1, 1'b1, 2'b11, 0, 14'h1555);
        partial(8'b1110_0111, 7);
        conv(3'b010, 1'b0, 1'b0, 2'b10, 4, encode(-4000));

        for (int it = 0; it < 24; it++) begin
            r = $urandom_range(0, 9);
            pdr = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : (r < 6) ? 2'b10 : 2'b11;
            u = 1'($urandom_range(0, 1));
            v = u ? $urandom_range(0, 16383) : $urandom_range(0, 16383) - 8192;
            conv(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), u, pdr,
                 $urandom_range(0, 4), encode(v));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule